// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block produces one interrupt line per side of a two-sided shared memory. The two highest words of the address space serve as mailboxes. When one side writes into the mailbox that belongs to the other side, the other side's interrupt is raised. That side drops its own interrupt by reading its mailbox. Both mailbox words remain plain storage words. The 8-bit message content is defined by the software and is never looked at here. The storage array sits outside this block.

Each side, called A and B, drives a set of control pins into the block: an active-low enable, a read/write select, an active-low output enable, a 15-bit address and a busy indication. A busy side cannot raise the partner's interrupt and cannot clear its own. Every access is sampled on the rising clock edge, and the interrupt outputs change one clock later. None of the pins carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `a_irq_n` and `b_irq_n` are high (inactive).
- R2: A write by side A (`a_en_n`=0, `a_rw_n`=0) to address 0x7FFF drives `b_irq_n` low one clock after the sampling edge.
- R3: A write by side B (`b_en_n`=0, `b_rw_n`=0) to address 0x7FFE drives `a_irq_n` low one clock after the sampling edge.
- R4: An access by side A to 0x7FFE with `a_en_n`=0 and `a_oe_n`=0 returns `a_irq_n` high one clock later. The level of `a_rw_n` does not matter.
- R5: An access by side B to 0x7FFF with `b_en_n`=0 and `b_oe_n`=0 returns `b_irq_n` high one clock later. The level of `b_rw_n` does not matter.
- R6: When a side's busy input is high (busy = 1), that side can neither raise the partner's interrupt nor clear its own. The affected flag keeps its value.
- R7: When a set and a clear reach the same flag in the same cycle, the set wins and the interrupt is asserted afterwards.
- R8: No change is made to either flag by an access to any address below 0x7FFE, by an access with the enable high, by a mailbox read with the output enable high, or by a write that a side makes to its own mailbox with the output enable high.
- R9: When there is no set or clear event, each interrupt output holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_en_n | input | 1 | Side A enable, active low |
| a_rw_n | input | 1 | Side A read (1) / write (0) |
| a_oe_n | input | 1 | Side A output enable, active low |
| a_addr | input | 15 | Side A address |
| a_busy | input | 1 | Side A busy, active high |
| b_en_n | input | 1 | Side B enable, active low |
| b_rw_n | input | 1 | Side B read (1) / write (0) |
| b_oe_n | input | 1 | Side B output enable, active low |
| b_addr | input | 15 | Side B address |
| b_busy | input | 1 | Side B busy, active high |
| a_irq_n | output | 1 | Interrupt to side A, active low |
| b_irq_n | output | 1 | Interrupt to side B, active low |

## Verification
The assertions check three rules on every cycle. A set event always leaves the flag asserted. A clear event with no set leaves the flag released. With no event the flag holds its value. They also check that both outputs stay stable while both sides are busy or neither side touches the top two words. The bench scenarios cover the address decode itself. They show that the correct mailbox is tied to each side, that the read/write level is ignored on a clear, and that the output enable and enable gating work. They also show the collision of a write and a read to the same mailbox in one cycle, and each busy input blocking only its own side's actions.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned NUM_SIDES = 2;

  typedef struct packed {
    logic post;  // raise the partner's flag
    logic ack;   // drop own flag
  } mbx_evt_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int unsigned ADDR_W  = 15,
  parameter bit          OWN_LSB = 1'b0
) (
  input  logic              en_n,
  input  logic              rw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output mbx_irq_pkg::mbx_evt_t evt
);
  localparam logic [ADDR_W-1:0] OWN_BOX  = {{(ADDR_W-1){1'b1}}, OWN_LSB};
  localparam logic [ADDR_W-1:0] PEER_BOX = {{(ADDR_W-1){1'b1}}, ~OWN_LSB};

  logic sel;
  assign sel = ~en_n & ~busy;

  always_comb begin
    evt.post = sel & ~rw_n & (addr == PEER_BOX);
    evt.ack  = sel & ~oe_n & (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R4
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en_n,
  input  logic              a_rw_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_busy,
  input  logic              b_en_n,
  input  logic              b_rw_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_busy,
  output logic              a_irq_n,
  output logic              b_irq_n
);
  import mbx_irq_pkg::*;

  localparam logic [ADDR_W-2:0] BOX_TAG = '1;

  logic [NUM_SIDES-1:0]    en_n_v, rw_n_v, oe_n_v, busy_v, flag_v;
  logic [ADDR_W-1:0]       addr_v [NUM_SIDES];
  mbx_evt_t                evt_v  [NUM_SIDES];

  assign en_n_v = {b_en_n, a_en_n};
  assign rw_n_v = {b_rw_n, a_rw_n};
  assign oe_n_v = {b_oe_n, a_oe_n};
  assign busy_v = {b_busy, a_busy};
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    mbx_port_dec #(.ADDR_W(ADDR_W), .OWN_LSB(s[0])) u_dec (
      .en_n (en_n_v[s]),
      .rw_n (rw_n_v[s]),
      .oe_n (oe_n_v[s]),
      .addr (addr_v[s]),
      .busy (busy_v[s]),
      .evt  (evt_v[s])
    );
    mbx_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_v[NUM_SIDES-1-s].post),
      .clr_i  (evt_v[s].ack),
      .flag_o (flag_v[s])
    );
  end

  assign a_irq_n = ~flag_v[0];
  assign b_irq_n = ~flag_v[1];

  // R6
  both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_busy && b_busy) |=> ($stable(a_irq_n) && $stable(b_irq_n)));

  // R8
  off_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr[ADDR_W-1:1] != BOX_TAG && b_addr[ADDR_W-1:1] != BOX_TAG)
      |=> ($stable(a_irq_n) && $stable(b_irq_n)));
endmodule

// File: tb/test_mbx_irq_ctrl.sv
`timescale 1ns/1ps
module test_mbx_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en_n = 1, a_rw_n = 1, a_oe_n = 1, a_busy = 0;
  logic b_en_n = 1, b_rw_n = 1, b_oe_n = 1, b_busy = 0;
  logic [14:0] a_addr = '0, b_addr = '0;
  logic a_irq_n, b_irq_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct { logic ea; logic eb; string req; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  mbx_irq_ctrl i_mbx_irq_ctrl (
    .clk, .rst_n,
    .a_en_n, .a_rw_n, .a_oe_n, .a_addr, .a_busy,
    .b_en_n, .b_rw_n, .b_oe_n, .b_addr, .b_busy,
    .a_irq_n, .b_irq_n
  );

  task automatic chk(logic ea, logic eb, string req);
    compared++;
    if (a_irq_n !== ea || b_irq_n !== eb) begin
      mismatched++;
      $display("FAIL %s: a_irq_n/b_irq_n = %b%b expected %b%b", req, a_irq_n, b_irq_n, ea, eb);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected outputs.
  task automatic drv(input logic [3:0] actl, input logic [14:0] aa,
                     input logic [3:0] bctl, input logic [14:0] ba,
                     input logic ea, input logic eb, input string req);
    @(negedge clk);
    {a_en_n, a_rw_n, a_oe_n, a_busy} = actl;
    {b_en_n, b_rw_n, b_oe_n, b_busy} = bctl;
    a_addr = aa;
    b_addr = ba;
    sb_q.push_back('{ea, eb, req});
  endtask

  // Monitor: compare just after the edge that registered the stimulus.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.ea, e.eb, e.req);
    end
  end

  // control nibble = {en_n, rw_n, oe_n, busy}
  localparam logic [3:0] IDLE = 4'b1110;
  localparam logic [3:0] WR   = 4'b0010;
  localparam logic [3:0] WROE = 4'b0000;
  localparam logic [3:0] RD   = 4'b0100;
  localparam logic [3:0] RDNO = 4'b0110;
  localparam logic [3:0] RDEN = 4'b1100;
  localparam logic [3:0] RDBZ = 4'b0101;
  localparam logic [3:0] WRBZ = 4'b0011;
  localparam logic [14:0] BOXA = 15'h7FFE;
  localparam logic [14:0] BOXB = 15'h7FFF;
  localparam logic [14:0] PLAIN = 15'h7FFD;

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(1, 1, "R1 during reset");
    rst_n = 1'b1;
    drv(IDLE, '0, IDLE, '0, 1, 1, "R1 after reset");
    drv(WR, BOXB, IDLE, '0, 1, 0, "R2 A writes B box");
    drv(IDLE, '0, IDLE, '0, 1, 0, "R9 hold set");
    drv(IDLE, '0, RD, BOXB, 1, 1, "R5 B reads own box");
    drv(IDLE, '0, WR, BOXA, 0, 1, "R3 B writes A box");
    drv(WROE, BOXA, IDLE, '0, 1, 1, "R4 clear with rw low");
    drv(IDLE, '0, WR, BOXA, 0, 1, "R3 set again");
    drv(RDNO, BOXA, IDLE, '0, 0, 1, "R8 oe high no clear");
    drv(RDEN, BOXA, IDLE, '0, 0, 1, "R8 enable high no clear");
    drv(RD, PLAIN, WR, PLAIN, 0, 1, "R8 plain address");
    drv(IDLE, '0, WR, BOXB, 0, 1, "R8 B writes own box");
    drv(RDBZ, BOXA, IDLE, '0, 0, 1, "R6 busy blocks clear");
    drv(RD, BOXA, IDLE, '0, 1, 1, "R4 clear with rw high");
    drv(WRBZ, BOXB, IDLE, '0, 1, 1, "R6 busy blocks set");
    drv(WR, BOXB, RD, BOXB, 1, 0, "R7 set beats clear on B");
    drv(RD, BOXA, WR, BOXA, 0, 0, "R7 set beats clear on A");
    drv(IDLE, '0, RDBZ, BOXB, 0, 0, "R6 B busy blocks clear");
    drv(RD, BOXA, RD, BOXB, 1, 1, "R4 R5 both clear");
    drv(IDLE, '0, IDLE, '0, 1, 1, "R9 hold clear");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule